// File: doc/BRIEF.md
# Frame Transmit Byte Sequencer

This block produces the byte stream for one outgoing bit-oriented data-link frame. The bytes come from a small on-chip RAM. A CPU-side write port loads three byte-wide settings: where the payload starts in RAM, how many payload bytes to send, and the control byte. A start strobe launches the frame and raises a busy flag. The sequencer presents the control byte first. It then reads the payload from RAM in ascending address order and hands each byte to a downstream serializer over a valid/ready interface. After the last byte is accepted it raises a one-cycle end-of-frame pulse, and busy then drops.

The RAM has one cycle of read latency. Its read data must stay unchanged until the next read enable. The sequencer issues the next read in the same cycle that the current byte is accepted. This lets it deliver one byte every cycle while the consumer holds ready high. Flag generation, bit stuffing and the frame check sequence are handled downstream.

The payload pointer stops at address 191 and never wraps. Hitting that address ends the payload early, whatever the programmed length. The settings are frozen while a frame is in flight.

Top module: `frame_tx_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `tx_valid` and `tx_eof` are 0. All three settings reset to 0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the setting chosen by `cfg_sel`: 0 = payload start address, 1 = payload length, 2 = control byte, 3 = no setting. A write is ignored while `busy`=1, and also in the same cycle as an accepted start.
- R3: `start`=1 while idle sets `busy` in the next cycle. `start` while `busy`=1 is ignored.
- R4: The first byte of every frame is the control byte.
- R5: The payload bytes follow the control byte. They are read from RAM at ascending addresses beginning at the start address, and at most `length` of them are sent.
- R6: A length of 0 gives a frame that holds only the control byte.
- R7: No RAM read is made above address 191. The payload ends after address 191 even if length remains. A start address above 191 sends only the control byte.
- R8: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` and `tx_data` hold steady in the next cycle.
- R9: With `tx_ready` held at 1, the frame's bytes appear on consecutive cycles with no gap.
- R10: `tx_eof` is 1 for exactly the one cycle after the last byte is accepted, with `tx_valid`=0. `busy` falls in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write enable |
| cfg_sel | input | 2 | Setting select (0 start, 1 length, 2 control, 3 none) |
| cfg_wdata | input | W | Setting write data |
| start | input | 1 | Frame start strobe |
| busy | output | 1 | Frame in flight |
| ram_rd_en | output | 1 | RAM read enable |
| ram_addr | output | W | RAM read address |
| ram_rdata | input | W | RAM read data, valid one cycle after a read and held until the next read |
| tx_data | output | W | Byte offered downstream |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_eof | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong pointer or remaining count shows up on `tx_data` at the very next accepted payload byte, as a wrong or shifted RAM value. A count error also changes the cycle in which `tx_eof` fires, so a frame that runs one byte too long or too short is caught in that cycle. A state machine that stalls or skips a state shows as a `tx_valid` bubble, or as a missing `tx_eof`, within one cycle of the affected acceptance. A broken write lockout stays hidden until the next frame starts, and then shows on its first byte or in its length.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CTRL = 2'd1,
    ST_INFO = 2'd2,
    ST_END  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/frame_tx_cfg.sv
module frame_tx_cfg
  import frame_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  input  logic         lock,
  output logic [W-1:0] base,
  output logic [W-1:0] len,
  output logic [W-1:0] ctrl
);

  logic [W-1:0] base_q, base_d;
  logic [W-1:0] len_q,  len_d;
  logic [W-1:0] ctrl_q, ctrl_d;
  logic         wr_ok;

  assign wr_ok = we && !lock;

  always_comb begin
    base_d = base_q;
    len_d  = len_q;
    ctrl_d = ctrl_q;
    if (wr_ok) begin
      case (cfg_sel_t'(sel))
        SEL_BASE: base_d = wdata;
        SEL_LEN:  len_d  = wdata;
        SEL_CTRL: ctrl_d = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_ok) begin
      base_q <= base_d;
      len_q  <= len_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign base = base_q;
  assign len  = len_q;
  assign ctrl = ctrl_q;

  // R2: settings frozen while locked
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(base_q) && $stable(len_q) && $stable(ctrl_q)));

endmodule

// File: rtl/frame_tx_fetch.sv
module frame_tx_fetch #(
  parameter int W         = 8,
  parameter int LAST_ADDR = 191
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_base,
  input  logic [W-1:0] load_len,
  input  logic         advance,
  output logic [W-1:0] addr,
  output logic         more
);

  localparam logic [W:0] LAST_P = LAST_ADDR[W:0];

  logic [W:0]   ptr_q, ptr_d;
  logic [W-1:0] rem_q, rem_d;
  logic         upd;

  assign upd = load || advance;

  always_comb begin
    ptr_d = ptr_q;
    rem_d = rem_q;
    if (load) begin
      ptr_d = {1'b0, load_base};
      rem_d = load_len;
    end else if (advance) begin
      ptr_d = ptr_q + 1'b1;
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rem_q <= '0;
    end else if (upd) begin
      ptr_q <= ptr_d;
      rem_q <= rem_d;
    end
  end

  assign more = (rem_q != '0) && (ptr_q <= LAST_P);
  assign addr = ptr_q[W-1:0];

  // R7: no read above the buffer end
  assert_no_read_past_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (ptr_q <= LAST_P));

  // R5: each read moves the pointer up by exactly one
  assert_ptr_ascends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/frame_tx_fsm.sv
module frame_tx_fsm
  import frame_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tx_ready,
  input  logic more,
  output logic busy,
  output logic tx_valid,
  output logic sel_ctrl,
  output logic eof,
  output logic load,
  output logic advance,
  output logic lock
);

  seq_state_t state_q, state_d;
  logic       accept;

  assign tx_valid = (state_q == ST_CTRL) || (state_q == ST_INFO);
  assign accept   = tx_valid && tx_ready;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    advance = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_CTRL;
        end
      end
      ST_CTRL, ST_INFO: begin
        if (accept) begin
          if (more) begin
            advance = 1'b1;
            state_d = ST_INFO;
          end else begin
            state_d = ST_END;
          end
        end
      end
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy     = (state_q != ST_IDLE);
  assign sel_ctrl = (state_q == ST_CTRL);
  assign eof      = (state_q == ST_END);
  assign lock     = busy || start;

  // R3: idle start raises busy
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && sel_ctrl));

  // R10: eof is a single cycle, then idle
  assert_eof_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> (!eof && !busy));

  assert_eof_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !tx_valid);

  // R9: more payload after an acceptance keeps valid high
  assert_no_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && more) |=> tx_valid);

endmodule

// File: rtl/frame_tx_seq.sv
module frame_tx_seq
  import frame_tx_pkg::*;
#(
  parameter int W         = 8,
  parameter int LAST_ADDR = 191
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  input  logic         start,
  output logic         busy,
  output logic         ram_rd_en,
  output logic [W-1:0] ram_addr,
  input  logic [W-1:0] ram_rdata,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic         tx_eof
);

  logic [W-1:0] base, len, ctrl;
  logic         lock, load, advance, more, sel_ctrl;

  frame_tx_cfg #(.W(W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .lock  (lock),
    .base  (base),
    .len   (len),
    .ctrl  (ctrl)
  );

  frame_tx_fetch #(.W(W), .LAST_ADDR(LAST_ADDR)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_base (base),
    .load_len  (len),
    .advance   (advance),
    .addr      (ram_addr),
    .more      (more)
  );

  frame_tx_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_ready (tx_ready),
    .more     (more),
    .busy     (busy),
    .tx_valid (tx_valid),
    .sel_ctrl (sel_ctrl),
    .eof      (tx_eof),
    .load     (load),
    .advance  (advance),
    .lock     (lock)
  );

  assign ram_rd_en = advance;
  assign tx_data   = sel_ctrl ? ctrl : ram_rdata;

  // R8: offered byte holds under backpressure
  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4: the first byte after a start is the control byte
  assert_ctrl_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (tx_valid && tx_data == ctrl));

endmodule

// File: tb/frame_tx_seq_tb.sv
module frame_tx_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic       start;
  logic       busy, ram_rd_en, tx_valid, tx_eof;
  logic [7:0] ram_addr, tx_data;
  logic [7:0] ram_rdata;
  logic       tx_ready;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ready_mode = 1'b0;
  int rphase = 0;

  logic [7:0] mem [256];
  logic [7:0] mq[$];
  logic [7:0] got[$];
  bit   m_busy, m_eof;
  logic [7:0] sh_base, sh_len, sh_ctrl;
  bit   eof_seen;
  bit   stall_prev;
  logic [7:0] stall_data;
  bit   cmp_on = 1'b0;

  always #4 clk = ~clk;

  frame_tx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .busy(busy),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_eof(tx_eof)
  );

  always @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_eof = 0; mq.delete();
      sh_base = 0; sh_len = 0; sh_ctrl = 0;
    end else begin
      automatic bit lk = m_busy || start;
      if (m_eof) begin
        m_eof = 0; m_busy = 0;
      end else if (m_busy) begin
        if (mq.size() > 0 && tx_ready) begin
          mq.delete(0);
          if (mq.size() == 0) m_eof = 1;
        end
      end else if (start) begin
        automatic int a = sh_base;
        automatic int n = 0;
        mq.delete();
        mq.push_back(sh_ctrl);
        while (n < sh_len && a <= 191) begin
          mq.push_back(mem[a]); a++; n++;
        end
        m_busy = 1;
      end
      if (cfg_we && !lk) begin
        case (cfg_sel)
          2'd0: sh_base = cfg_wdata;
          2'd1: sh_len  = cfg_wdata;
          2'd2: sh_ctrl = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  // port monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) got.push_back(tx_data);
      if (tx_eof) eof_seen = 1;
      stall_prev = tx_valid && !tx_ready;
      stall_data = tx_data;
    end else begin
      stall_prev = 0;
    end
  end

  // cycle compare
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      automatic bit ev = m_busy && !m_eof && (mq.size() > 0);
      chk(busy === m_busy, "R3 busy", busy, m_busy);
      chk(tx_eof === m_eof, "R10 eof", tx_eof, m_eof);
      chk(tx_valid === ev, "R9 valid", tx_valid, ev);
      if (ev) chk(tx_data === mq[0], "R5 data", tx_data, mq[0]);
      if (stall_prev)
        chk(tx_valid === 1'b1 && tx_data === stall_data, "R8 hold", tx_data, stall_data);
    end
  end

  always @(negedge clk) begin
    tx_ready <= ready_mode ? ((rphase % 3) != 0) : 1'b1;
    rphase++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic go();
    @(negedge clk);
    got.delete(); eof_seen = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000 && !eof_seen; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frame_chk(input logic [7:0] ectrl, input int en, input string tag);
    chk(got.size() == en, {tag, " count"}, got.size(), en);
    if (got.size() > 0) chk(got[0] == ectrl, "R4 first byte", got[0], ectrl);
    chk(busy == 1'b0, {tag, " idle after"}, busy, 0);
  endtask

  task automatic setup(input logic [7:0] b, input logic [7:0] l, input logic [7:0] c);
    wr(2'd0, b); wr(2'd1, l); wr(2'd2, c);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ 8'hA5);
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; start = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && tx_valid === 1'b0 && tx_eof === 1'b0, "R1 reset", {busy, tx_valid, tx_eof}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && tx_valid === 1'b0 && tx_eof === 1'b0, "R1 after reset", {busy, tx_valid, tx_eof}, 0);
    cmp_on = 1;

    // R1: reset settings are zero, so an immediate frame is control 0, no payload
    go(); wait_end(); frame_chk(8'h00, 1, "R1 zero settings");

    // R5: plain frame
    setup(8'h10, 8'd4, 8'h3C);
    go(); wait_end(); frame_chk(8'h3C, 5, "R5 basic");

    // R6: zero length
    wr(2'd1, 8'd0);
    go(); wait_end(); frame_chk(8'h3C, 1, "R6 empty");

    // R7: end at 191
    setup(8'hBC, 8'd10, 8'h11);
    go(); wait_end(); frame_chk(8'h11, 5, "R7 buffer end");

    // R7: start above 191
    setup(8'hC5, 8'd3, 8'h22);
    go(); wait_end(); frame_chk(8'h22, 1, "R7 high start");

    // R8: backpressure
    ready_mode = 1;
    setup(8'h20, 8'd20, 8'h5A);
    go(); wait_end(); frame_chk(8'h5A, 21, "R8 stalled");
    ready_mode = 0;

    // R2, R3: writes and start while busy are ignored
    setup(8'h40, 8'd30, 8'h77);
    go();
    wr(2'd2, 8'h99); wr(2'd1, 8'd2); wr(2'd0, 8'h00);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    wait_end(); frame_chk(8'h77, 31, "R3 busy frame");
    go(); wait_end(); frame_chk(8'h77, 31, "R2 locked writes");

    // R2: write concurrent with start
    @(negedge clk);
    got.delete(); eof_seen = 0;
    start = 1; cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = 8'hEE;
    @(negedge clk);
    start = 0; cfg_we = 0;
    wait_end(); frame_chk(8'h77, 31, "R2 concurrent write");

    // R2: select 3 writes nothing
    wr(2'd3, 8'h01);
    go(); wait_end(); frame_chk(8'h77, 31, "R2 null select");

    // R7, R9: long frame stopped by buffer end
    setup(8'h00, 8'hFF, 8'hC3);
    go(); wait_end(); frame_chk(8'hC3, 193, "R7 long");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule